// File: doc/BRIEF.md
# Step-Halving Calibration Search Controller

This block hunts for an 8-bit trim setting that brings an external measurement inside a tolerance window around its target. After a start pulse it proposes candidate settings one at a time. Each candidate goes out on a one-cycle request, and the block then waits for a comparator verdict of below, within or above. Writing the setting to the trimmed circuit, letting it settle and measuring it all happen outside this block.

The search begins at a fixed start value and moves by a fixed initial step. A "below" verdict makes the step point upward and an "above" verdict makes it point downward. The step magnitude is halved only after the search has overshot in both directions, and it never drops below 1. The search ends when a verdict is "within", or when the target has been crossed at unit step from both sides. A cycle-count timeout aborts a search whose measurements never settle. Each of the three endings has its own status code.

Top module: `cal_step_search`

## Requirements
- R1: After reset, `busy_o`, `req_o` and `done_o` are 0, `status_o` is 0 (no result) and `result_o` is 0.
- R2: A `start_i` pulse seen while idle makes `req_o` high for exactly one cycle in the next cycle, with `req_value_o` = START_VAL + INIT_STEP (0x88 by default). A `start_i` seen while a search is running is ignored.
- R3: A response is taken only when `rsp_valid_i` is high while the block waits after a request; a response during the request cycle is ignored. Verdict code 2'b00 means within. A within verdict ends the search with status 2'b01, and `result_o` equal to the candidate it answered.
- R4: Verdict 2'b01 (below) makes the next candidate the previous candidate plus the step magnitude. Verdicts 2'b10 and 2'b11 (above) make it the previous candidate minus the magnitude. The next request follows one cycle after the response is taken.
- R5: Once a below verdict and an above verdict have both been recorded since the last halving, the step magnitude is halved, with a floor of 1, and both records are cleared.
- R6: Once a below verdict and an above verdict have each been received while the step magnitude was 1, the search ends with status 2'b10, and `result_o` equal to the last candidate.
- R7: Candidates are saturated to the range 0 to 255 rather than wrapping around.
- R8: A search still running TIMEOUT_CYC cycles after its first request cycle is aborted with status 2'b11, and `result_o` equal to the last candidate issued. A verdict that ends the search in the same cycle takes priority.
- R9: `done_o` is a single-cycle pulse after which `busy_o` is 0. `status_o` and `result_o` then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| req_o | output | 1 | One-cycle request to apply and measure a candidate |
| req_value_o | output | VAL_W | Candidate setting carried by the request |
| rsp_valid_i | input | 1 | Comparator verdict is valid |
| rsp_cmp_i | input | 2 | Verdict: 00 within, 01 below, 10/11 above |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a search ends |
| status_o | output | 2 | 00 none, 01 within hit, 10 unit-step convergence, 11 timeout |
| result_o | output | VAL_W | Last candidate of the finished search |

## Verification
The bench keeps the default start value, initial step and 8-bit width. It builds the block with TIMEOUT_CYC = 600 instead of a two-second cycle count. That short limit lets the bench reach timeout aborts several times in one run: once with a plant that never answers, where the busy time can be counted exactly, and once each with plants that always report below or always report above, which drive the candidates into saturation at 255 and at 0 until the limit expires.

// File: rtl/cal_search_pkg.sv
package cal_search_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } cal_state_e;

    // comparator verdict codes
    localparam logic [1:0] CMP_WITHIN = 2'b00;
    localparam logic [1:0] CMP_BELOW  = 2'b01;

    // completion status codes
    localparam logic [1:0] RES_NONE    = 2'b00;
    localparam logic [1:0] RES_HIT     = 2'b01;
    localparam logic [1:0] RES_CONV    = 2'b10;
    localparam logic [1:0] RES_TIMEOUT = 2'b11;

    typedef struct packed {
        logic seen_lo;   // below verdict since last halving
        logic seen_hi;   // above verdict since last halving
        logic unit_lo;   // below verdict at unit step
        logic unit_hi;   // above verdict at unit step
    } cal_flags_t;

endpackage

// File: rtl/cal_step_update.sv
module cal_step_update
    import cal_search_pkg::*;
#(
    parameter int MAG_W = 4
) (
    input  logic [MAG_W-1:0] mag_i,
    input  cal_flags_t       flags_i,
    input  logic [1:0]       cmp_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o,
    output cal_flags_t       flags_o,
    output logic             conv_o
);

    logic unit_step;

    always_comb begin
        unit_step = (mag_i == MAG_W'(1));
        flags_o   = flags_i;
        neg_o     = (cmp_i != CMP_BELOW);
        if (cmp_i == CMP_BELOW) begin
            flags_o.seen_lo = 1'b1;
            if (unit_step) flags_o.unit_lo = 1'b1;
        end else begin
            flags_o.seen_hi = 1'b1;
            if (unit_step) flags_o.unit_hi = 1'b1;
        end
        conv_o = flags_o.unit_lo && flags_o.unit_hi;
        mag_o  = mag_i;
        if (flags_o.seen_lo && flags_o.seen_hi) begin
            mag_o = mag_i >> 1;
            if (mag_o == '0) mag_o = MAG_W'(1);
            flags_o.seen_lo = 1'b0;
            flags_o.seen_hi = 1'b0;
        end
    end

endmodule

// File: rtl/cal_next_cand.sv
module cal_next_cand #(
    parameter int VAL_W = 8,
    parameter int MAG_W = 4
) (
    input  logic [VAL_W-1:0] cur_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             neg_i,
    output logic [VAL_W-1:0] cand_o
);

    localparam int SUM_W = VAL_W + 2;
    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << VAL_W) - 1);

    logic signed [SUM_W-1:0] base_s;
    logic signed [SUM_W-1:0] step_s;
    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        base_s = $signed({2'b00, cur_i});
        step_s = $signed({{(SUM_W-MAG_W){1'b0}}, mag_i});
        sum_s  = neg_i ? (base_s - step_s) : (base_s + step_s);
        if (sum_s < 0)
            cand_o = '0;
        else if (sum_s > TOP)
            cand_o = '1;
        else
            cand_o = sum_s[VAL_W-1:0];
    end

endmodule

// File: rtl/cal_timeout.sv
module cal_timeout #(
    parameter int LIMIT = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    AST_TIMER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0); // R8

endmodule

// File: rtl/cal_step_search.sv
module cal_step_search
    import cal_search_pkg::*;
#(
    parameter int VAL_W       = 8,
    parameter int START_VAL   = 128,
    parameter int INIT_STEP   = 8,
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             req_o,
    output logic [VAL_W-1:0] req_value_o,
    input  logic             rsp_valid_i,
    input  logic [1:0]       rsp_cmp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [VAL_W-1:0] result_o
);

    localparam int MAG_W = $clog2(INIT_STEP + 1);
    localparam logic [VAL_W-1:0] START_V = VAL_W'(START_VAL);
    localparam logic [MAG_W-1:0] STEP_V  = MAG_W'(INIT_STEP);

    typedef struct packed {
        cal_state_e       state;
        logic [VAL_W-1:0] cur;
        logic [MAG_W-1:0] mag;
        logic             neg;
        cal_flags_t       flags;
        logic [1:0]       status;
    } cal_regs_t;

    cal_regs_t s_d, s_q;

    logic [VAL_W-1:0] cand_w;
    logic [MAG_W-1:0] upd_mag;
    logic             upd_neg;
    cal_flags_t       upd_flags;
    logic             upd_conv;
    logic             tmo_run;
    logic             tmo_expired;

    cal_next_cand #(.VAL_W(VAL_W), .MAG_W(MAG_W)) i_next_cand (
        .cur_i  (s_q.cur),
        .mag_i  (s_q.mag),
        .neg_i  (s_q.neg),
        .cand_o (cand_w)
    );

    cal_step_update #(.MAG_W(MAG_W)) i_step_update (
        .mag_i   (s_q.mag),
        .flags_i (s_q.flags),
        .cmp_i   (rsp_cmp_i),
        .mag_o   (upd_mag),
        .neg_o   (upd_neg),
        .flags_o (upd_flags),
        .conv_o  (upd_conv)
    );

    assign tmo_run = (s_q.state == ST_REQ) || (s_q.state == ST_WAIT);

    cal_timeout #(.LIMIT(TIMEOUT_CYC)) i_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .expired_o (tmo_expired)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state  = ST_REQ;
                    s_d.cur    = START_V;
                    s_d.mag    = STEP_V;
                    s_d.neg    = 1'b0;
                    s_d.flags  = '0;
                    s_d.status = RES_NONE;
                end
            end
            ST_REQ: begin
                if (tmo_expired) begin
                    s_d.state  = ST_DONE;
                    s_d.status = RES_TIMEOUT;
                    s_d.cur    = cand_w;
                end else begin
                    s_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    s_d.cur = cand_w;
                    if (rsp_cmp_i == CMP_WITHIN) begin
                        s_d.state  = ST_DONE;
                        s_d.status = RES_HIT;
                    end else begin
                        s_d.mag   = upd_mag;
                        s_d.neg   = upd_neg;
                        s_d.flags = upd_flags;
                        if (upd_conv) begin
                            s_d.state  = ST_DONE;
                            s_d.status = RES_CONV;
                        end else if (tmo_expired) begin
                            s_d.state  = ST_DONE;
                            s_d.status = RES_TIMEOUT;
                        end else begin
                            s_d.state = ST_REQ;
                        end
                    end
                end else if (tmo_expired) begin
                    s_d.state  = ST_DONE;
                    s_d.status = RES_TIMEOUT;
                    s_d.cur    = cand_w;
                end
            end
            ST_DONE: s_d.state = ST_IDLE;
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state  <= ST_IDLE;
            s_q.cur    <= '0;
            s_q.mag    <= STEP_V;
            s_q.neg    <= 1'b0;
            s_q.flags  <= '0;
            s_q.status <= RES_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o       = (s_q.state == ST_REQ);
    assign req_value_o = cand_w;
    assign busy_o      = tmo_run;
    assign done_o      = (s_q.state == ST_DONE);
    assign status_o    = s_q.status;
    assign result_o    = s_q.cur;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o); // R2

    AST_HIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) && (status_o == RES_HIT)
            |-> $past(rsp_valid_i && (rsp_cmp_i == CMP_WITHIN))); // R3

    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (s_q.mag != '0) && (s_q.mag <= STEP_V)); // R5

    AST_CONV_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) && (status_o == RES_CONV) |-> $past(s_q.mag) == MAG_W'(1)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !done_o && !$rose(busy_o) |=> $stable(status_o) || busy_o); // R9

endmodule

// File: tb/test_cal_step_search.sv
`timescale 1ns/1ps
module test_cal_step_search;

    localparam int TMO = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       req_o;
    logic [7:0] req_value_o;
    logic       rsp_valid_i = 1'b0;
    logic [1:0] rsp_cmp_i = 2'b00;
    logic       busy_o;
    logic       done_o;
    logic [1:0] status_o;
    logic [7:0] result_o;

    int checks = 0;
    int failures = 0;

    // bench model of the search
    int m_cur, m_mag, m_neg, f_lo, f_hi, u_lo, u_hi;

    always #2 clk = ~clk;

    cal_step_search #(
        .VAL_W(8), .START_VAL(128), .INIT_STEP(8), .TIMEOUT_CYC(TMO)
    ) i_cal_step_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_o(req_o), .req_value_o(req_value_o),
        .rsp_valid_i(rsp_valid_i), .rsp_cmp_i(rsp_cmp_i),
        .busy_o(busy_o), .done_o(done_o),
        .status_o(status_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_cand();
        int s;
        s = m_neg ? (m_cur - m_mag) : (m_cur + m_mag);
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    // returns 0 while searching, otherwise the expected status code
    function automatic int m_apply(input int cmp);
        m_cur = m_cand();
        if (cmp == 0) return 1;
        if (cmp == 1) begin
            f_lo = 1; if (m_mag == 1) u_lo = 1; m_neg = 0;
        end else begin
            f_hi = 1; if (m_mag == 1) u_hi = 1; m_neg = 1;
        end
        if (u_lo && u_hi) return 2;
        if (f_lo && f_hi) begin
            m_mag = m_mag / 2;
            if (m_mag == 0) m_mag = 1;
            f_lo = 0; f_hi = 0;
        end
        return 0;
    endfunction

    // plant: 0 window, 1 never within, 2 always below, 3 silent,
    // 4 always above, 5 window with above coded as 11
    function automatic int plant(input int mode, input int v, input int tgt, input int tol);
        case (mode)
            0, 5: begin
                if (v >= tgt - tol && v <= tgt + tol) return 0;
                if (v < tgt) return 1;
                return (mode == 5) ? 3 : 2;
            end
            1: return (v <= tgt) ? 1 : 2;
            2: return 1;
            default: return 2;
        endcase
    endfunction

    task automatic run_search(input int mode, input int tgt, input int tol, input bit inject);
        int fin = 0;
        int pend = -1;
        int nbusy = 0;
        int last_req = -1;
        int nreq = 0;
        int pc;
        bit seen_done = 0;
        string tag;
        m_cur = 128; m_mag = 8; m_neg = 0; f_lo = 0; f_hi = 0; u_lo = 0; u_hi = 0;
        tag = (mode == 1) ? "R5" : ((mode == 2 || mode == 4) ? "R7" : "R4");
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int guard = 0; guard < 5000; guard++) begin
            if (done_o) begin seen_done = 1; break; end
            rsp_valid_i = 1'b0;
            start_i = 1'b0;
            if (busy_o) nbusy++;
            if (req_o) begin
                chk(fin == 0, "R6 no request after end", nreq, -1);
                chk(int'(req_value_o) == m_cand(), (nreq == 0) ? "R2 first candidate" : tag,
                    int'(req_value_o), m_cand());
                last_req = int'(req_value_o);
                nreq++;
                if (mode != 3) pend = $urandom_range(0, 3);
                if (inject && nreq == 2) begin
                    rsp_valid_i = 1'b1; rsp_cmp_i = 2'b00; start_i = 1'b1;
                end
            end else if (pend == 0) begin
                pc = plant(mode, m_cand(), tgt, tol);
                rsp_valid_i = 1'b1;
                rsp_cmp_i = 2'(pc);
                fin = m_apply(pc);
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
            @(negedge clk);
        end
        rsp_valid_i = 1'b0;
        start_i = 1'b0;
        chk(seen_done, "R9 search ends", 0, 1);
        if (fin == 0) begin
            chk(int'(status_o) == 3, "R8 timeout status", int'(status_o), 3);
            if (mode == 3) chk(nbusy == TMO, "R8 busy cycles", nbusy, TMO);
        end else begin
            chk(int'(status_o) == fin, (fin == 1) ? "R3 hit status" : "R6 converge status",
                int'(status_o), fin);
        end
        chk(int'(result_o) == last_req, "R3 R6 R8 result", int'(result_o), last_req);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9 done pulse", int'(done_o), 0);
        repeat (3) @(negedge clk);
        chk(int'(result_o) == last_req && !busy_o && !req_o, "R9 hold result",
            int'(result_o), last_req);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy_o && !req_o && !done_o, "R1 reset controls", int'(busy_o), 0);
        chk(status_o == 2'b00 && result_o == 8'h00, "R1 reset values", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!req_o && !busy_o, "R2 no request without start", int'(req_o), 0);

        run_search(0, 136, 0, 1'b0);   // R3 immediate hit
        run_search(1, 100, 0, 1'b1);   // R5 R6 convergence, R2/R3 ignored inputs
        run_search(5, 40, 1, 1'b0);    // R4 code 11 as above
        run_search(2, 0, 0, 1'b0);     // R7 saturate high, R8
        run_search(4, 0, 0, 1'b0);     // R7 saturate low, R8
        run_search(3, 0, 0, 1'b0);     // R8 exact timeout
        run_search(1, 0, 0, 1'b0);     // R7 R6 at the low edge
        run_search(1, 255, 0, 1'b0);   // R7 R6 at the high edge
        for (int i = 0; i < 24; i++) begin
            t = $urandom_range(0, 2);
            run_search((t == 2) ? 5 : t, $urandom_range(0, 255), $urandom_range(0, 3),
                       1'(i % 3 == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule